// File: doc/BRIEF.md
# Operand Latency Hazard Scoreboard

This block sits at the issue stage of an in-order pipeline and decides whether the instruction that is offered can issue this cycle. Each offered instruction brings a class code, up to two source register indices and one destination register index, each with its own enable. The block keeps a small countdown for every architectural register and one for the condition codes. It also keeps a short record of the last memory operation. When any dependency has not yet aged enough for this producer and consumer pair, it raises `stall`.

Latency here means the number of bubble cycles the consumer must wait after the producer issues. A latency of 0 means the consumer can issue in the very next cycle. When an instruction issues, its destination entry is loaded with the producer's latency, and the entry counts down once per cycle. A consumer compares each source's count against the slack its pair allows. Loads are assumed to hit the first-level cache. The table is not written while the offered instruction is stalled or absent.

Class codes on `iss_class`: 0 = ALU, 1 = compare (an ALU operation that also sets the condition codes), 2 = load, 3 = store, 4 = conditional branch (reads the condition codes), 5 to 7 = generic integer operation.

Top module: `hazard_scoreboard`

## Requirements
- R1: A consumer that reads a register last written by a load (class 2) is held for exactly 2 bubble cycles after the load issues, on either source port.
- R2: A store (class 3) that reads a register last written by class 0 or 1 issues in the next cycle with no bubble.
- R3: A branch (class 4) issued right after a compare (class 1) has no bubble. It reads only the condition codes.
- R4: Every other read-after-write pair (producer class 0, 1 or 5 to 7, except the cases in R2 and R3) costs exactly 1 bubble.
- R5: A write to a register whose previous writer issued in the immediately preceding cycle costs 1 bubble, for any producer class. Two back-to-back compares also cost 1 bubble, because both write the condition codes.
- R6: A write to a register that the previous instruction only read costs no bubble.
- R7: A store following a load or a store costs 1 bubble, and so does a load following a store. A load following a load costs none.
- R8: Back-to-back branches cost no bubble.
- R9: Register index 0 is never recorded as a destination and always reads as ready.
- R10: `stall` is low whenever `iss_valid` is low. An instruction that is stalled and then withdrawn leaves no trace in the table.
- R11: After reset every register, the condition codes and the memory order record are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 3 | Class code of the offered instruction |
| src1 | input | 5 | First source register index |
| src1_en | input | 1 | First source is read |
| src2 | input | 5 | Second source register index |
| src2_en | input | 1 | Second source is read |
| dst | input | 5 | Destination register index |
| dst_en | input | 1 | Destination is written |
| stall | output | 1 | Offered instruction must not issue this cycle |

## Verification
`stall` is a combinational function of the offered instruction and the table, so it is due in the same cycle the inputs are driven. The bench drives inputs on the falling edge and samples `stall` 1 ns later. A producer's effect on the table appears one rising edge after it is accepted. The bench therefore offers each consumer on the falling edge that follows the producer's accepting edge. It then counts the cycles in which `stall` stays high until the consumer is taken, and compares that bubble count with the pair latency worked out from the requirements.

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard #(
  parameter int NREG = 32,
  parameter int CW   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic [2:0]              iss_class,
  input  logic [$clog2(NREG)-1:0] src1,
  input  logic                    src1_en,
  input  logic [$clog2(NREG)-1:0] src2,
  input  logic                    src2_en,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic                    dst_en,
  output logic                    stall
);
  localparam int AW = $clog2(NREG);
  localparam logic [2:0] K_ALU = 3'd0, K_CMP = 3'd1, K_LD = 3'd2, K_ST = 3'd3, K_BR = 3'd4;
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] LAT_LD  = CW'(2);
  localparam logic [CW-1:0] LAT_DEF = CW'(1);

  logic [CW-1:0] cnt   [NREG];
  logic          ld_q  [NREG];
  logic          alu_q [NREG];
  logic [CW-1:0] cc_cnt;
  logic          mem_pend, mem_st;
  logic          s1_hz, s2_hz, ww_hz, cc_hz, mem_hz, hazard;

  wire is_ld  = iss_class == K_LD;
  wire is_st  = iss_class == K_ST;
  wire is_mem = is_ld | is_st;
  wire is_alu = (iss_class == K_ALU) | (iss_class == K_CMP);
  wire accept = iss_valid & ~hazard;
  wire wr     = accept & dst_en & (dst != '0);

  always_comb begin
    s1_hz  = src1_en && src1 != '0 && cnt[src1] > ((is_st && alu_q[src1]) ? ONE : ZERO);
    s2_hz  = src2_en && src2 != '0 && cnt[src2] > ((is_st && alu_q[src2]) ? ONE : ZERO);
    ww_hz  = dst_en && dst != '0 && cnt[dst] > (ld_q[dst] ? ONE : ZERO);
    cc_hz  = (iss_class == K_BR && cc_cnt > ONE) || (iss_class == K_CMP && cc_cnt != ZERO);
    mem_hz = is_mem && mem_pend && (mem_st || is_st);
    hazard = s1_hz | s2_hz | ww_hz | cc_hz | mem_hz;
  end

  assign stall = iss_valid & hazard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        cnt[i]   <= ZERO;
        ld_q[i]  <= 1'b0;
        alu_q[i] <= 1'b0;
      end
      cc_cnt   <= ZERO;
      mem_pend <= 1'b0;
      mem_st   <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr && dst == AW'(i)) begin
          cnt[i]   <= is_ld ? LAT_LD : LAT_DEF;
          ld_q[i]  <= is_ld;
          alu_q[i] <= is_alu;
        end else if (cnt[i] != ZERO) begin
          cnt[i] <= cnt[i] - ONE;
        end
      end
      if (accept && iss_class == K_CMP) cc_cnt <= ONE;
      else if (cc_cnt != ZERO)          cc_cnt <= cc_cnt - ONE;
      if (accept && is_mem) begin
        mem_pend <= 1'b1;
        mem_st   <= is_st;
      end else begin
        mem_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hazard_scoreboard_chk.sv
module hazard_scoreboard_chk #(
  parameter int NREG = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    iss_valid,
  input logic [2:0]              iss_class,
  input logic [$clog2(NREG)-1:0] src1,
  input logic                    src1_en,
  input logic                    src2_en,
  input logic [$clog2(NREG)-1:0] dst,
  input logic                    dst_en,
  input logic                    stall
);
  wire acc     = iss_valid & ~stall;
  wire ld_wr   = acc && iss_class == 3'd2 && dst_en && dst != '0;
  wire alu_wr  = acc && iss_class == 3'd0 && dst_en && dst != '0;
  wire st_done = acc && iss_class == 3'd3;

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall);

  assert_load_use_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ld_wr) && iss_valid && src1_en && src1 == $past(dst)) |-> stall);

  assert_alu_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alu_wr) && iss_valid && iss_class == 3'd0 && src1_en && src1 == $past(dst)) |-> stall);

  assert_store_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_done) && iss_valid && iss_class == 3'd3) |-> stall);

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == 3'd0 && src1_en && src1 == '0 && !src2_en && !dst_en) |-> !stall);

  assert_branch_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class == 3'd4 && !src1_en && !src2_en && !dst_en) |-> !stall);
endmodule

bind hazard_scoreboard hazard_scoreboard_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
  .src1(src1), .src1_en(src1_en), .src2_en(src2_en),
  .dst(dst), .dst_en(dst_en), .stall(stall)
);

// File: tb/sim_hazard_scoreboard.sv
`timescale 1ns/1ps
module sim_hazard_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic [2:0] iss_class = '0;
  logic [4:0] src1 = '0, src2 = '0, dst = '0;
  logic       src1_en = 1'b0, src2_en = 1'b0, dst_en = 1'b0;
  logic       stall;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  hazard_scoreboard u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
    .src1(src1), .src1_en(src1_en), .src2(src2), .src2_en(src2_en),
    .dst(dst), .dst_en(dst_en), .stall(stall)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int cls, input int s1, input int s2, input int d);
    iss_class = 3'(cls);
    src1_en = s1 >= 0; src1 = 5'(s1 < 0 ? 0 : s1);
    src2_en = s2 >= 0; src2 = 5'(s2 < 0 ? 0 : s2);
    dst_en  = d  >= 0; dst  = 5'(d  < 0 ? 0 : d);
  endtask

  task automatic pair(input int pc, input int ps1, input int ps2, input int pd,
                      input int cc, input int cs1, input int cs2, input int cd,
                      input int exp, input string tag);
    int n;
    iss_valid = 1'b0;
    repeat (4) @(negedge clk);
    drive(pc, ps1, ps2, pd);
    iss_valid = 1'b1;
    @(negedge clk);
    drive(cc, cs1, cs2, cd);
    n = 0;
    #1;
    while (stall && n < 8) begin
      n++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    iss_valid = 1'b0;
    check(n, exp, tag);
  endtask

  function automatic int expect_bub(input int p, input int c);
    int raw, mem, cmpw;
    bit pw, cr;
    pw   = (p != 3) && (p != 4);
    cr   = (c != 4);
    raw  = (pw && cr) ? ((p == 2 ? 2 : 1) - ((c == 3 && p <= 1) ? 1 : 0)) : 0;
    cmpw = (p == 1 && c == 1) ? 1 : 0;
    mem  = ((p == 2 || p == 3) && (c == 2 || c == 3) && (p == 3 || c == 3)) ? 1 : 0;
    if (cmpw > raw) raw = cmpw;
    return (mem > raw) ? mem : raw;
  endfunction

  function automatic string tag_of(input int p, input int c);
    bit pw;
    pw = (p != 3) && (p != 4);
    if ((p == 2 || p == 3) && (c == 2 || c == 3) && !pw) return "R7";
    if (p == 2 && c != 4) return "R1";
    if (c == 3 && p <= 1) return "R2";
    if (c == 4 && p == 1) return "R3";
    if (c == 4 && p == 4) return "R8";
    if (p == 4 || p == 3 || c == 4) return "R8";
    return "R4";
  endfunction

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: everything ready after reset
    drive(0, 5, 6, 7); iss_valid = 1'b1; #1;
    check(stall, 0, "R11 alu after reset");
    drive(3, 5, 6, -1); #1;
    check(stall, 0, "R11 store after reset");
    drive(1, -1, -1, 8); #1;
    check(stall, 0, "R11 compare after reset");
    @(negedge clk); iss_valid = 1'b0;

    // pair sweep over classes 0..5: producer writes r5, consumer reads r5
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 6; c++)
        pair(p, -1, -1, (p == 3 || p == 4) ? -1 : 5,
             c, (c == 4) ? -1 : 5, -1, (c == 3 || c == 4) ? -1 : 9,
             expect_bub(p, c), tag_of(p, c));

    // R1 second source port
    pair(2, -1, -1, 5, 0, -1, 5, -1, 2, "R1 via src2");
    // R5 write after write
    pair(0, -1, -1, 5, 0, -1, -1, 5, 1, "R5 alu then alu");
    pair(2, -1, -1, 5, 0, -1, -1, 5, 1, "R5 load then alu");
    pair(5, -1, -1, 5, 0, -1, -1, 5, 1, "R5 generic then alu");
    pair(1, -1, -1, 6, 1, -1, -1, 7, 1, "R5 compare then compare");
    // R6 write after read
    pair(0, 5, -1, 6, 0, -1, -1, 5, 0, "R6 alu overwrites read reg");
    // R7 load then load
    pair(2, -1, -1, 5, 2, 6, -1, 8, 0, "R7 load then load");
    pair(3, 6, -1, -1, 2, 7, -1, 8, 1, "R7 store then load");
    // R9 register zero
    pair(2, -1, -1, 0, 0, 0, -1, -1, 0, "R9 read r0 after load r0");
    pair(0, -1, -1, 0, 0, -1, -1, 0, 0, "R9 write r0 twice");

    // R10 withdrawn stalled instruction leaves no trace
    repeat (4) @(negedge clk);
    drive(2, -1, -1, 5); iss_valid = 1'b1;
    @(negedge clk);
    drive(0, 5, -1, 7); #1;
    check(stall, 1, "R10 consumer held");
    iss_valid = 1'b0; #1;
    check(stall, 0, "R10 stall low without valid");
    @(negedge clk);
    drive(0, 7, -1, -1); iss_valid = 1'b1; #1;
    check(stall, 0, "R10 withdrawn dst not recorded");
    @(negedge clk); iss_valid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule